// File: doc/BRIEF.md
# Delayed-Branch Fetch Sequencer

This block is the program-counter and fetch-sequencing unit of a small in-order pipelined core. It has two stages. Each cycle it presents a fetch address. One cycle later it holds the fetched word in a single decode slot, tagged with its address, a valid bit and a delay-slot marker. The decode logic outside the block looks at the word in that slot and returns four things: whether it is a branch, whether the branch is the delayed form, whether its condition holds, and its target address.

A delayed branch never stalls the stream, taken or not. The word that follows it (the delay slot) always completes. When the branch is taken, the word at the target follows the delay slot. A taken non-delayed branch annuls the sequential word that was already fetched, which leaves one bubble. A branch that sits in a delay slot is illegal: the block raises an error flag while that word occupies the slot and executes it as a no-op. A counter of retired slots supports cycle accounting. The stall input freezes every register.

Reset is asynchronous and active low, and is expected to be released synchronously to the clock.

Top module: `dbr_fetch_seq`

## Requirements
- R1: While reset is asserted, the outputs hold these values: `fetch_addr` = RESET_VEC, `slot_valid` = 0, `slot_err` = 0 and `retire_cnt` = 0.
- R2: A valid slot that is not a branch, and not in a delay slot, retires at address A. The next valid slot is then at A+2, and it appears at the next non-stalled edge.
- R3: A taken delayed branch at A retires the delay slot at A+2 at the next non-stalled edge, with `slot_valid` = 1. The target word retires one non-stalled edge after that.
- R4: A delayed branch at A that is not taken retires A+2 and then A+4, each one non-stalled edge after the word before it.
- R5: A taken non-delayed branch makes `slot_valid` = 0 after the next non-stalled edge. The target word retires two non-stalled edges after the branch.
- R6: A non-delayed branch that is not taken causes no bubble: A+2 retires at the next non-stalled edge.
- R7: Bit 0 of `br_target` is ignored. `fetch_addr` bit 0 is always 0.
- R8: A branch (`br_valid` = 1) decoded in a delay slot drives `slot_err` = 1 while it is in the slot. It is executed as a plain word: the next address is sequential and no redirect happens.
- R9: While `stall` = 1, `fetch_addr`, `slot_addr`, `slot_valid` and `retire_cnt` keep their values at the clock edge.
- R10: `retire_cnt` grows by one at every non-stalled edge at which `slot_valid` = 1. It wraps modulo 2^CNT_W.
- R11: When `slot_valid` = 0, the branch inputs have no effect: the next fetch address is the current one plus 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall | input | 1 | Freezes the whole sequencer when high |
| br_valid | input | 1 | Word in the slot is a branch |
| br_delayed | input | 1 | The branch is the delayed form |
| br_taken | input | 1 | The branch condition holds |
| br_target | input | ADDR_W | Branch target address |
| fetch_addr | output | ADDR_W | Address being fetched this cycle |
| slot_valid | output | 1 | Slot holds a live word (0 = bubble or annulled) |
| slot_addr | output | ADDR_W | Address of the word in the slot |
| slot_err | output | 1 | Branch found in a delay slot |
| retire_cnt | output | CNT_W | Retired-slot count, wraps |

## Verification
The bench builds the block with ADDR_W = 16, RESET_VEC = 0x0100 and CNT_W = 6. The narrow counter makes it wrap many times within one run, so the wrap in R10 is checked. The bench uses a 64-word program that is indexed by address. Its targets all fall inside that program, so random branching keeps coming back to a directed prefix. That prefix contains these cases:
- a taken delayed branch;
- a taken non-delayed branch that is followed closely by another;
- a delayed branch that is not taken, with an illegal branch in its delay slot;
- an odd target.

Random stalls fall across every one of these sequences.

// File: rtl/dbr_pkg.sv
package dbr_pkg;

  // Action chosen for the word in the decode slot
  typedef enum logic [1:0] {
    ACT_SEQ       = 2'd0,  // sequential, no redirect
    ACT_DLY_TAKEN = 2'd1,  // delayed branch, taken
    ACT_DLY_FALL  = 2'd2,  // delayed branch, not taken
    ACT_FLUSH     = 2'd3   // non-delayed taken: annul fetched word
  } dbr_act_e;

endpackage

// File: rtl/dbr_redirect.sv
module dbr_redirect
  import dbr_pkg::*;
(
  input  logic     slot_valid,
  input  logic     slot_in_delay,
  input  logic     br_valid,
  input  logic     br_delayed,
  input  logic     br_taken,
  output dbr_act_e act,
  output logic     illegal
);

  logic is_branch;

  assign is_branch = slot_valid & br_valid;

  always_comb begin
    act     = ACT_SEQ;
    illegal = 1'b0;
    if (is_branch && slot_in_delay) begin
      illegal = 1'b1;          // treated as a no-op
    end else if (is_branch) begin
      if (br_delayed) begin
        act = br_taken ? ACT_DLY_TAKEN : ACT_DLY_FALL;
      end else if (br_taken) begin
        act = ACT_FLUSH;
      end
    end
  end

endmodule

// File: rtl/dbr_pc_stage.sv
module dbr_pc_stage
  import dbr_pkg::*;
#(
  parameter int              ADDR_W     = 32,
  parameter int              INSN_BYTES = 2,
  parameter logic [ADDR_W-1:0] RESET_VEC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  dbr_act_e          act,
  input  logic [ADDR_W-1:0] target,
  output logic [ADDR_W-1:0] pc_q
);

  localparam logic [ADDR_W-1:0] STEP_V     = ADDR_W'(INSN_BYTES);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ADDR_W'(INSN_BYTES - 1);

  logic [ADDR_W-1:0] tgt_al;
  logic [ADDR_W-1:0] pc_d;

  assign tgt_al = target & ~ALIGN_MASK;

  always_comb begin
    unique case (act)
      ACT_DLY_TAKEN, ACT_FLUSH: pc_d = tgt_al;
      default:                  pc_d = pc_q + STEP_V;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= RESET_VEC;
    end else if (adv) begin
      pc_q <= pc_d;
    end
  end

  // R9
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(pc_q));

  // R7
  pc_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_q & ALIGN_MASK) == '0);

  // R3
  dly_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv && act == ACT_DLY_TAKEN |=> pc_q == ($past(target) & ~ALIGN_MASK));

endmodule

// File: rtl/dbr_slot_stage.sv
module dbr_slot_stage
  import dbr_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 16,
  parameter int INSN_BYTES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  dbr_act_e          act,
  input  logic [ADDR_W-1:0] fetch_pc,
  output logic              slot_valid,
  output logic [ADDR_W-1:0] slot_addr,
  output logic              slot_in_delay,
  output logic [CNT_W-1:0]  retire_cnt
);

  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(INSN_BYTES);

  logic              valid_d;
  logic [ADDR_W-1:0] addr_d;
  logic              dly_d;
  logic [CNT_W-1:0]  cnt_d;

  always_comb begin
    valid_d = (act != ACT_FLUSH);
    addr_d  = fetch_pc;
    dly_d   = (act == ACT_DLY_TAKEN) || (act == ACT_DLY_FALL);
    cnt_d   = retire_cnt + {{(CNT_W-1){1'b0}}, slot_valid};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_valid    <= 1'b0;
      slot_addr     <= '0;
      slot_in_delay <= 1'b0;
      retire_cnt    <= '0;
    end else if (adv) begin
      slot_valid    <= valid_d;
      slot_addr     <= addr_d;
      slot_in_delay <= dly_d;
      retire_cnt    <= cnt_d;
    end
  end

  // R5
  flush_annul_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv && act == ACT_FLUSH |=> !slot_valid);

  // R3 R4
  dslot_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv && (act == ACT_DLY_TAKEN || act == ACT_DLY_FALL) |=> slot_valid && slot_in_delay);

  // R2
  seq_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv && act == ACT_SEQ && slot_valid && !slot_in_delay
      |=> slot_valid && slot_addr == $past(slot_addr) + STEP_V);

  // R9
  slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(retire_cnt) && $stable(slot_addr) && $stable(slot_valid));

endmodule

// File: rtl/dbr_fetch_seq.sv
module dbr_fetch_seq
  import dbr_pkg::*;
#(
  parameter int                ADDR_W     = 32,
  parameter int                CNT_W      = 16,
  parameter int                INSN_BYTES = 2,
  parameter logic [ADDR_W-1:0] RESET_VEC  = 32'h0000_0100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall,
  input  logic              br_valid,
  input  logic              br_delayed,
  input  logic              br_taken,
  input  logic [ADDR_W-1:0] br_target,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic              slot_valid,
  output logic [ADDR_W-1:0] slot_addr,
  output logic              slot_err,
  output logic [CNT_W-1:0]  retire_cnt
);

  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(INSN_BYTES);

  dbr_act_e act;
  logic     adv;
  logic     slot_in_delay;

  assign adv = ~stall;

  dbr_redirect i_redirect (
    .slot_valid    (slot_valid),
    .slot_in_delay (slot_in_delay),
    .br_valid      (br_valid),
    .br_delayed    (br_delayed),
    .br_taken      (br_taken),
    .act           (act),
    .illegal       (slot_err)
  );

  dbr_pc_stage #(
    .ADDR_W     (ADDR_W),
    .INSN_BYTES (INSN_BYTES),
    .RESET_VEC  (RESET_VEC)
  ) i_pc (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv    (adv),
    .act    (act),
    .target (br_target),
    .pc_q   (fetch_addr)
  );

  dbr_slot_stage #(
    .ADDR_W     (ADDR_W),
    .CNT_W      (CNT_W),
    .INSN_BYTES (INSN_BYTES)
  ) i_slot (
    .clk           (clk),
    .rst_n         (rst_n),
    .adv           (adv),
    .act           (act),
    .fetch_pc      (fetch_addr),
    .slot_valid    (slot_valid),
    .slot_addr     (slot_addr),
    .slot_in_delay (slot_in_delay),
    .retire_cnt    (retire_cnt)
  );

  // R8
  illegal_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv && slot_err |=> fetch_addr == $past(fetch_addr) + STEP_V && slot_valid);

  // R6
  nd_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv && slot_valid && !slot_in_delay && br_valid && !br_delayed && !br_taken
      |=> slot_valid && slot_addr == $past(slot_addr) + STEP_V);

  // R11
  bubble_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !slot_valid |=> fetch_addr == $past(fetch_addr) + STEP_V);

endmodule

// File: tb/test_dbr_fetch_seq.sv
module test_dbr_fetch_seq;

  localparam int          AW    = 16;
  localparam int          CW    = 6;
  localparam logic [15:0] BASE  = 16'h0100;
  localparam int          NCYC  = 4000;

  logic          clk;
  logic          rst_n;
  logic          stall;
  logic          br_valid, br_delayed, br_taken;
  logic [AW-1:0] br_target;
  logic [AW-1:0] fetch_addr;
  logic          slot_valid;
  logic [AW-1:0] slot_addr;
  logic          slot_err;
  logic [CW-1:0] retire_cnt;

  dbr_fetch_seq #(
    .ADDR_W(AW), .CNT_W(CW), .INSN_BYTES(2), .RESET_VEC(BASE)
  ) i_dbr_fetch_seq (
    .clk(clk), .rst_n(rst_n), .stall(stall),
    .br_valid(br_valid), .br_delayed(br_delayed), .br_taken(br_taken),
    .br_target(br_target), .fetch_addr(fetch_addr), .slot_valid(slot_valid),
    .slot_addr(slot_addr), .slot_err(slot_err), .retire_cnt(retire_cnt)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  // program: kind 0 plain, 1 delayed taken, 2 delayed not taken,
  // 3 non-delayed taken, 4 non-delayed not taken
  int          kind [64];
  logic [15:0] tgt  [64];

  function automatic int idx_of(logic [15:0] a);
    logic [15:0] d;
    d = (a - BASE) >> 1;
    return int'(d[5:0]);
  endfunction

  function automatic logic [15:0] addr_of(int i, bit odd);
    return BASE + 16'(2 * i) + {15'd0, odd};
  endfunction

  task automatic check(bit ok, string req, string what, int act_v, int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act_v, exp_v);
    end
  endtask

  initial begin
    #(10 * 60000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] exp_addr, pend, prev_fetch;
    bit          in_slot, pend_v, first_ret, prev_stall, prev_bubble, started;
    int          exp_gap, gap_cnt, n_ret, k;
    bit          ill;

    void'($urandom(32'd20240611));
    for (int i = 0; i < 64; i++) begin
      int r;
      r = int'($urandom % 10);
      kind[i] = (r < 5) ? 0 : r - 5;
      tgt[i]  = addr_of(int'($urandom % 64), 1'($urandom % 2));
    end
    // directed prefix
    kind[0]  = 0;
    kind[1]  = 1; tgt[1]  = addr_of(10, 0);
    kind[2]  = 0;
    kind[10] = 3; tgt[10] = addr_of(20, 0);
    kind[20] = 3; tgt[20] = addr_of(30, 0);
    kind[30] = 2; tgt[30] = addr_of(45, 0);
    kind[31] = 3; tgt[31] = addr_of(40, 0);   // illegal in slot
    kind[32] = 1; tgt[32] = addr_of(50, 1);   // odd target
    kind[33] = 1; tgt[33] = addr_of(60, 0);   // illegal in slot
    kind[50] = 1; tgt[50] = addr_of(5, 0);
    kind[51] = 0;
    kind[5]  = 4;
    kind[6]  = 0;

    rst_n = 1'b0; stall = 1'b0;
    br_valid = 1'b0; br_delayed = 1'b0; br_taken = 1'b0; br_target = '0;
    repeat (3) @(negedge clk);
    // R1
    check(fetch_addr == BASE, "R1", "reset fetch_addr", int'(fetch_addr), int'(BASE));
    check(slot_valid == 1'b0, "R1", "reset slot_valid", int'(slot_valid), 0);
    check(slot_err == 1'b0, "R1", "reset slot_err", int'(slot_err), 0);
    check(retire_cnt == '0, "R1", "reset retire_cnt", int'(retire_cnt), 0);
    rst_n = 1'b1;

    exp_addr = BASE; pend = '0; pend_v = 0; in_slot = 0;
    first_ret = 1; exp_gap = 1; gap_cnt = 0; n_ret = 0;
    started = 0; prev_stall = 0; prev_bubble = 0; prev_fetch = '0;

    for (int cyc = 0; cyc < NCYC; cyc++) begin
      if (started) begin
        // R10
        check(retire_cnt == CW'(n_ret), "R10", "retire_cnt", int'(retire_cnt), n_ret % 64);
        // R7
        check(fetch_addr[0] == 1'b0, "R7", "fetch_addr bit0", int'(fetch_addr), int'(fetch_addr & 16'hFFFE));
        if (prev_stall)
          check(fetch_addr == prev_fetch, "R9", "fetch frozen", int'(fetch_addr), int'(prev_fetch));
        else if (prev_bubble)
          check(fetch_addr == prev_fetch + 16'd2, "R11", "bubble ignores branch inputs",
                int'(fetch_addr), int'(prev_fetch + 16'd2));
      end
      started = 1;

      stall = (cyc > 200) && (($urandom % 5) == 0);
      if (slot_valid) begin
        k = kind[idx_of(slot_addr)];
        br_valid   = (k != 0);
        br_delayed = (k == 1) || (k == 2);
        br_taken   = (k == 1) || (k == 3);
        br_target  = tgt[idx_of(slot_addr)];
      end else begin
        k = 0;
        br_valid   = 1'($urandom);
        br_delayed = 1'($urandom);
        br_taken   = 1'($urandom);
        br_target  = 16'($urandom);
      end
      #1;

      if (slot_valid && !stall) begin
        ill = in_slot && (k != 0);
        check(slot_addr == exp_addr, "R2 R3 R4 R5 R6", "retired address",
              int'(slot_addr), int'(exp_addr));
        check(slot_err == ill, "R8", "slot_err", int'(slot_err), int'(ill));
        if (!first_ret)
          check(gap_cnt + 1 == exp_gap, "R3 R5", "cycles between retirements",
                gap_cnt + 1, exp_gap);
        first_ret = 0;
        gap_cnt = 0;
        n_ret++;
        // reference model step
        exp_gap = 1;
        if (pend_v) begin
          exp_addr = pend;
          pend_v = 0;
        end else begin
          exp_addr = exp_addr + 16'd2;
        end
        in_slot = 0;
        if (!ill) begin
          case (k)
            1: begin pend = tgt[idx_of(slot_addr)] & 16'hFFFE; pend_v = 1; in_slot = 1; end
            2: in_slot = 1;
            3: begin exp_addr = tgt[idx_of(slot_addr)] & 16'hFFFE; exp_gap = 2; end
            default: ;
          endcase
        end
      end else if (!stall) begin
        gap_cnt++;
      end

      prev_stall  = stall;
      prev_bubble = !stall && !slot_valid;
      prev_fetch  = fetch_addr;
      @(negedge clk);
      #0;
      if (cyc == NCYC - 1) begin
        check(retire_cnt == CW'(n_ret), "R10", "final retire_cnt", int'(retire_cnt), n_ret % 64);
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule